// File: doc/BRIEF.md
# Asymmetric Dual-Port RAM with Mailbox Flags

This block is a synchronous dual-port memory whose two sides see the same storage at different widths. The wide side addresses 16-bit words and can write or read either byte of a word, or both. The narrow side addresses the same words but moves one byte at a time, with a select input that picks the upper or lower half. All chip, output and write enables are active low. Inputs are sampled on the rising clock edge. Read data comes out one cycle after the read is sampled, together with per-lane valid flags that stand in for tri-state outputs.

Two locations near the top of the address space act as mailboxes. When the wide side writes the top word, an interrupt is raised toward the narrow side. When the narrow side writes the word just below it, an interrupt is raised toward the wide side. Each interrupt is cleared when its receiving side reads that location. Active-low busy flags warn the side that arrives second at an address the other side already holds. Busy is only advisory: accesses still complete.

Top module: `asym_mbx_ram`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both busy outputs and both interrupt outputs are 1 and every read-valid output is 0.
- R2: A wide-side write (lCeN=0, lWeN=0, both lane enables low) stores the whole 16-bit word. A wide-side read (lCeN=0, lOeN=0, lWeN=1) returns it on lRdData one cycle after it is sampled, with lRdVld=2'b11.
- R3: The wide-side lane enables gate both writes and reads: lHiEnN selects bits 15:8 and lRdVld[1], lLoEnN selects bits 7:0 and lRdVld[0]. A lane whose enable is high is not written. On a read it reports valid 0 and data 0.
- R4: The narrow side reaches bits 15:8 of the addressed word when rUpper=1 and bits 7:0 when rUpper=0, for both reads and writes. A narrow-side read returns its byte one cycle after it is sampled, with rRdVld=1.
- R5: A write attempted while that side's chip enable is high, or while its write enable is high, leaves the stored word unchanged.
- R6: Read-valid outputs are 0 in the cycle after a sample in which that side's chip enable or output enable was high.
- R7: A wide-side write of at least one lane to the all-ones address drives rIntN low from the next cycle. A narrow-side read of the all-ones address drives it back high.
- R8: A narrow-side write to the all-ones-minus-one address drives lIntN low from the next cycle. A wide-side read (at least one lane) of that address drives it back high.
- R9: If a set and a clear of the same interrupt are sampled in the same cycle, the interrupt is set.
- R10: When both chip enables are low and the addresses are equal, the busy output of the side that arrived later goes low in the next cycle. It returns high in the cycle after the addresses differ or either chip enable rises. This works in either direction, and both busy outputs are never low together.
- R11: When both sides arrive at the same address in the same sampled cycle, rBusyN goes low and lBusyN stays high.
- R12: Busy does not block a write. When both sides write the same byte of the same word in one cycle, the wide side's data is stored. Writes to different bytes of the same word in one cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lAddr | input | ADDR_W | Wide-side word address |
| lCeN | input | 1 | Wide-side chip enable, active low |
| lOeN | input | 1 | Wide-side output enable, active low |
| lWeN | input | 1 | Wide-side write enable, active low |
| lHiEnN | input | 1 | Wide-side upper lane enable, active low |
| lLoEnN | input | 1 | Wide-side lower lane enable, active low |
| lWrData | input | 2*BYTE_W | Wide-side write data |
| lRdData | output | 2*BYTE_W | Wide-side read data, 0 on invalid lanes |
| lRdVld | output | 2 | Wide-side per-lane read valid (bit 1 upper) |
| rAddr | input | ADDR_W | Narrow-side word address |
| rCeN | input | 1 | Narrow-side chip enable, active low |
| rOeN | input | 1 | Narrow-side output enable, active low |
| rWeN | input | 1 | Narrow-side write enable, active low |
| rUpper | input | 1 | Narrow-side byte select, 1 for upper |
| rWrData | input | BYTE_W | Narrow-side write data |
| rRdData | output | BYTE_W | Narrow-side read data, 0 when invalid |
| rRdVld | output | 1 | Narrow-side read valid |
| lBusyN | output | 1 | Wide-side busy, active low |
| rBusyN | output | 1 | Narrow-side busy, active low |
| lIntN | output | 1 | Interrupt toward wide side, active low |
| rIntN | output | 1 | Interrupt toward narrow side, active low |

## Verification
The hardest situations to reach are the ones that depend on which side arrived at an address first. These are same-cycle arrival, a late arrival on either side, and a set and clear of one mailbox flag landing in the same sample. The stimulus idles both sides for a cycle first, so that arrival history is known. It then drops the chip enables on a chosen cycle, or in the same cycle, and holds them while the busy outputs are sampled. Same-cycle collisions are set up by driving both sides' write or read enables in one cycle at one address. The stored result is then read back through the wide side.

// File: rtl/asym_mbx_pkg.sv
package asym_mbx_pkg;

  localparam int LANES = 2;

  typedef struct packed {
    logic [LANES-1:0] lWrLane;
    logic [LANES-1:0] rWrLane;
    logic [LANES-1:0] lRdLane;
    logic             rRd;
    logic             rRdUpper;
  } ramStrobe_t;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LBUSY = 2'd1,
    OWN_RBUSY = 2'd2
  } busyOwner_t;

endpackage

// File: rtl/asym_mbx_busy.sv
module asym_mbx_busy
  import asym_mbx_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lAct,
  input  logic              rAct,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [ADDR_W-1:0] rAddr,
  output logic              lBusyN,
  output logic              rBusyN
);

  logic              prevLAct, prevRAct;
  logic [ADDR_W-1:0] prevLAddr, prevRAddr;
  logic              lArrive, rArrive, match;
  busyOwner_t        owner, ownerNxt;

  // A side "arrives" when it becomes active or moves to a new address
  assign lArrive = lAct && (!prevLAct || (lAddr != prevLAddr));
  assign rArrive = rAct && (!prevRAct || (rAddr != prevRAddr));
  assign match   = lAct && rAct && (lAddr == rAddr);

  always_comb begin
    ownerNxt = owner;
    if (!match) begin
      ownerNxt = OWN_NONE;
    end else if (owner == OWN_NONE) begin
      if (lArrive && !rArrive) ownerNxt = OWN_LBUSY;
      else                     ownerNxt = OWN_RBUSY;  // right later, or a tie
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLAct  <= 1'b0;
      prevRAct  <= 1'b0;
      prevLAddr <= '0;
      prevRAddr <= '0;
      owner     <= OWN_NONE;
    end else begin
      prevLAct  <= lAct;
      prevRAct  <= rAct;
      prevLAddr <= lAddr;
      prevRAddr <= rAddr;
      owner     <= ownerNxt;
    end
  end

  assign lBusyN = (owner != OWN_LBUSY);
  assign rBusyN = (owner != OWN_RBUSY);

endmodule

// File: rtl/asym_mbx_ctrl.sv
module asym_mbx_ctrl
  import asym_mbx_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lCeN,
  input  logic              lOeN,
  input  logic              lWeN,
  input  logic              lHiEnN,
  input  logic              lLoEnN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rCeN,
  input  logic              rOeN,
  input  logic              rWeN,
  input  logic              rUpper,
  output ramStrobe_t        strb,
  output logic              lBusyN,
  output logic              rBusyN,
  output logic              lIntN,
  output logic              rIntN
);

  localparam logic [ADDR_W-1:0] MBX_TO_R = '1;
  localparam logic [ADDR_W-1:0] MBX_TO_L = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic [LANES-1:0] lSel, rSel, lWrLane;
  logic lWrReq, lRdReq, rWrReq, rRdReq, sameAddr;
  logic rFlagSet, rFlagClr, lFlagSet, lFlagClr;
  logic rFlag, lFlag;

  assign lSel     = {~lHiEnN, ~lLoEnN};
  assign rSel     = rUpper ? 2'b10 : 2'b01;
  assign lWrReq   = !lCeN && !lWeN;
  assign lRdReq   = !lCeN && !lOeN && lWeN;
  assign rWrReq   = !rCeN && !rWeN;
  assign rRdReq   = !rCeN && !rOeN && rWeN;
  assign sameAddr = (lAddr == rAddr);
  assign lWrLane  = lWrReq ? lSel : '0;

  always_comb begin
    strb          = '0;
    strb.lWrLane  = lWrLane;
    // Same-byte collision: the wide side keeps the lane
    strb.rWrLane  = rWrReq ? (rSel & ~(sameAddr ? lWrLane : '0)) : '0;
    strb.lRdLane  = lRdReq ? lSel : '0;
    strb.rRd      = rRdReq;
    strb.rRdUpper = rUpper;
  end

  assign rFlagSet = lWrReq && (|lSel) && (lAddr == MBX_TO_R);
  assign rFlagClr = rRdReq && (rAddr == MBX_TO_R);
  assign lFlagSet = rWrReq && (rAddr == MBX_TO_L);
  assign lFlagClr = lRdReq && (|lSel) && (lAddr == MBX_TO_L);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rFlag <= 1'b0;
      lFlag <= 1'b0;
    end else begin
      if (rFlagSet)      rFlag <= 1'b1;
      else if (rFlagClr) rFlag <= 1'b0;
      if (lFlagSet)      lFlag <= 1'b1;
      else if (lFlagClr) lFlag <= 1'b0;
    end
  end

  assign rIntN = !rFlag;
  assign lIntN = !lFlag;

  asym_mbx_busy #(.ADDR_W(ADDR_W)) u_busy (
    .clk    (clk),
    .rstN   (rstN),
    .lAct   (!lCeN),
    .rAct   (!rCeN),
    .lAddr  (lAddr),
    .rAddr  (rAddr),
    .lBusyN (lBusyN),
    .rBusyN (rBusyN)
  );

endmodule

// File: rtl/asym_mbx_dpath.sv
module asym_mbx_dpath
  import asym_mbx_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ramStrobe_t              strb,
  input  logic [ADDR_W-1:0]       lAddr,
  input  logic [ADDR_W-1:0]       rAddr,
  input  logic [LANES*BYTE_W-1:0] lWrData,
  input  logic [BYTE_W-1:0]       rWrData,
  output logic [LANES*BYTE_W-1:0] lRdData,
  output logic [LANES-1:0]        lRdVld,
  output logic [BYTE_W-1:0]       rRdData,
  output logic                    rRdVld
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] lLaneQ [LANES];
  logic [BYTE_W-1:0] rLaneQ [LANES];
  logic [BYTE_W-1:0] lOutLane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] memLane [DEPTH];

    // Wide side written second so it wins; control also masks the narrow side
    always_ff @(posedge clk) begin
      if (strb.rWrLane[g]) memLane[rAddr] <= rWrData;
      if (strb.lWrLane[g]) memLane[lAddr] <= lWrData[g*BYTE_W +: BYTE_W];
    end

    assign lLaneQ[g] = memLane[lAddr];
    assign rLaneQ[g] = memLane[rAddr];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lOutLane[g] <= '0;
        lRdVld[g]   <= 1'b0;
      end else begin
        lOutLane[g] <= strb.lRdLane[g] ? lLaneQ[g] : '0;
        lRdVld[g]   <= strb.lRdLane[g];
      end
    end

    assign lRdData[g*BYTE_W +: BYTE_W] = lOutLane[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rRdData <= '0;
      rRdVld  <= 1'b0;
    end else begin
      rRdData <= strb.rRd ? rLaneQ[strb.rRdUpper] : '0;
      rRdVld  <= strb.rRd;
    end
  end

endmodule

// File: rtl/asym_mbx_ram.sv
module asym_mbx_ram
  import asym_mbx_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       lAddr,
  input  logic                    lCeN,
  input  logic                    lOeN,
  input  logic                    lWeN,
  input  logic                    lHiEnN,
  input  logic                    lLoEnN,
  input  logic [2*BYTE_W-1:0]     lWrData,
  output logic [2*BYTE_W-1:0]     lRdData,
  output logic [1:0]              lRdVld,
  input  logic [ADDR_W-1:0]       rAddr,
  input  logic                    rCeN,
  input  logic                    rOeN,
  input  logic                    rWeN,
  input  logic                    rUpper,
  input  logic [BYTE_W-1:0]       rWrData,
  output logic [BYTE_W-1:0]       rRdData,
  output logic                    rRdVld,
  output logic                    lBusyN,
  output logic                    rBusyN,
  output logic                    lIntN,
  output logic                    rIntN
);

  ramStrobe_t strb;

  asym_mbx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .lAddr  (lAddr),
    .lCeN   (lCeN),
    .lOeN   (lOeN),
    .lWeN   (lWeN),
    .lHiEnN (lHiEnN),
    .lLoEnN (lLoEnN),
    .rAddr  (rAddr),
    .rCeN   (rCeN),
    .rOeN   (rOeN),
    .rWeN   (rWeN),
    .rUpper (rUpper),
    .strb   (strb),
    .lBusyN (lBusyN),
    .rBusyN (rBusyN),
    .lIntN  (lIntN),
    .rIntN  (rIntN)
  );

  asym_mbx_dpath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .lAddr   (lAddr),
    .rAddr   (rAddr),
    .lWrData (lWrData),
    .rWrData (rWrData),
    .lRdData (lRdData),
    .lRdVld  (lRdVld),
    .rRdData (rRdData),
    .rRdVld  (rRdVld)
  );

endmodule

// File: rtl/asym_mbx_chk.sv
module asym_mbx_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] lAddr,
  input logic              lCeN,
  input logic              lOeN,
  input logic              lWeN,
  input logic              lHiEnN,
  input logic              lLoEnN,
  input logic [1:0]        lRdVld,
  input logic [ADDR_W-1:0] rAddr,
  input logic              rCeN,
  input logic              rOeN,
  input logic              rWeN,
  input logic              rRdVld,
  input logic              lBusyN,
  input logic              rBusyN,
  input logic              lIntN,
  input logic              rIntN
);

  localparam logic [ADDR_W-1:0] TOP  = '1;
  localparam logic [ADDR_W-1:0] NEXT = {{(ADDR_W-1){1'b1}}, 1'b0};

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |-> (lBusyN && rBusyN && lIntN && rIntN && !rRdVld && lRdVld == 2'b00)); // R1

  AST_BUSY_NOT_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !(!lBusyN && !rBusyN)); // R10

  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (!lBusyN || !rBusyN) |-> $past(!lCeN && !rCeN && lAddr == rAddr)); // R10

  AST_LANE_HI_GATED: assert property (@(posedge clk) disable iff (!rstN)
    lRdVld[1] |-> $past(!lHiEnN)); // R3

  AST_LANE_LO_GATED: assert property (@(posedge clk) disable iff (!rstN)
    lRdVld[0] |-> $past(!lLoEnN)); // R3

  AST_RVLD_NEEDS_OE: assert property (@(posedge clk) disable iff (!rstN)
    rRdVld |-> $past(!rCeN && !rOeN)); // R6

  AST_LVLD_NEEDS_OE: assert property (@(posedge clk) disable iff (!rstN)
    (lRdVld != 2'b00) |-> $past(!lCeN && !lOeN)); // R6

  AST_RINT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!lCeN && !lWeN && (!lHiEnN || !lLoEnN) && lAddr == TOP) |=> !rIntN); // R7

  AST_RINT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (!rCeN && !rOeN && rWeN && rAddr == TOP &&
     !(!lCeN && !lWeN && (!lHiEnN || !lLoEnN) && lAddr == TOP)) |=> rIntN); // R7

  AST_LINT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!rCeN && !rWeN && rAddr == NEXT) |=> !lIntN); // R8

endmodule

bind asym_mbx_ram asym_mbx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .lAddr  (lAddr),
  .lCeN   (lCeN),
  .lOeN   (lOeN),
  .lWeN   (lWeN),
  .lHiEnN (lHiEnN),
  .lLoEnN (lLoEnN),
  .lRdVld (lRdVld),
  .rAddr  (rAddr),
  .rCeN   (rCeN),
  .rOeN   (rOeN),
  .rWeN   (rWeN),
  .rRdVld (rRdVld),
  .lBusyN (lBusyN),
  .rBusyN (rBusyN),
  .lIntN  (lIntN),
  .rIntN  (rIntN)
);

// File: tb/asym_mbx_ram_bench.sv
module asym_mbx_ram_bench;

  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] lAddr = '0, rAddr = '0;
  logic lCeN = 1'b1, lOeN = 1'b1, lWeN = 1'b1, lHiEnN = 1'b1, lLoEnN = 1'b1;
  logic rCeN = 1'b1, rOeN = 1'b1, rWeN = 1'b1, rUpper = 1'b0;
  logic [2*BYTE_W-1:0] lWrData = '0, lRdData;
  logic [1:0] lRdVld;
  logic [BYTE_W-1:0] rWrData = '0, rRdData;
  logic rRdVld, lBusyN, rBusyN, lIntN, rIntN;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  asym_mbx_ram #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_asym_mbx_ram (
    .clk(clk), .rstN(rstN),
    .lAddr(lAddr), .lCeN(lCeN), .lOeN(lOeN), .lWeN(lWeN),
    .lHiEnN(lHiEnN), .lLoEnN(lLoEnN), .lWrData(lWrData),
    .lRdData(lRdData), .lRdVld(lRdVld),
    .rAddr(rAddr), .rCeN(rCeN), .rOeN(rOeN), .rWeN(rWeN),
    .rUpper(rUpper), .rWrData(rWrData), .rRdData(rRdData), .rRdVld(rRdVld),
    .lBusyN(lBusyN), .rBusyN(rBusyN), .lIntN(lIntN), .rIntN(rIntN)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idleAll();
    lCeN = 1'b1; lOeN = 1'b1; lWeN = 1'b1; lHiEnN = 1'b1; lLoEnN = 1'b1;
    rCeN = 1'b1; rOeN = 1'b1; rWeN = 1'b1;
  endtask

  task automatic lWrite(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                        input logic hiN, input logic loN);
    lAddr = a; lWrData = d; lCeN = 1'b0; lWeN = 1'b0; lOeN = 1'b1;
    lHiEnN = hiN; lLoEnN = loN;
    step();
    idleAll();
  endtask

  task automatic lRead(input logic [ADDR_W-1:0] a, input logic hiN, input logic loN,
                       output logic [15:0] d, output logic [1:0] v);
    lAddr = a; lCeN = 1'b0; lOeN = 1'b0; lWeN = 1'b1; lHiEnN = hiN; lLoEnN = loN;
    step();
    d = lRdData; v = lRdVld;
    idleAll();
  endtask

  task automatic rWrite(input logic [ADDR_W-1:0] a, input logic up, input logic [7:0] d);
    rAddr = a; rUpper = up; rWrData = d; rCeN = 1'b0; rWeN = 1'b0; rOeN = 1'b1;
    step();
    idleAll();
  endtask

  task automatic rRead(input logic [ADDR_W-1:0] a, input logic up,
                       output logic [7:0] d, output logic v);
    rAddr = a; rUpper = up; rCeN = 1'b0; rOeN = 1'b0; rWeN = 1'b1;
    step();
    d = rRdData; v = rRdVld;
    idleAll();
  endtask

  task automatic testReset();
    chk("R1 lBusyN after reset", lBusyN, 1);
    chk("R1 rBusyN after reset", rBusyN, 1);
    chk("R1 lIntN after reset", lIntN, 1);
    chk("R1 rIntN after reset", rIntN, 1);
    chk("R1 lRdVld after reset", lRdVld, 0);
    chk("R1 rRdVld after reset", rRdVld, 0);
  endtask

  task automatic testWord();
    logic [15:0] d; logic [1:0] v;
    lWrite(10'd5, 16'h2492, 0, 0);
    lRead(10'd5, 0, 0, d, v);
    chk("R2 word data", d, 16'h2492);
    chk("R2 word valid", v, 2'b11);
    lWrite(10'd6, 16'hC3A5, 0, 0);
    lRead(10'd6, 0, 0, d, v);
    chk("R2 second word data", d, 16'hC3A5);
  endtask

  task automatic testLanes();
    logic [15:0] d; logic [1:0] v;
    lWrite(10'd200, 16'hFFFF, 0, 0);
    lWrite(10'd200, 16'h0011, 1, 0);
    lRead(10'd200, 0, 0, d, v);
    chk("R3 low-lane write only", d, 16'hFF11);
    lWrite(10'd200, 16'h2200, 0, 1);
    lRead(10'd200, 1, 0, d, v);
    chk("R3 low-lane read data", d, 16'h0011);
    chk("R3 low-lane read valid", v, 2'b01);
    lRead(10'd200, 0, 1, d, v);
    chk("R3 high-lane read data", d, 16'h2200);
    chk("R3 high-lane read valid", v, 2'b10);
  endtask

  task automatic testNarrow();
    logic [15:0] d; logic [1:0] v; logic [7:0] b; logic bv;
    lWrite(10'd100, 16'hA5C3, 0, 0);
    rRead(10'd100, 1, b, bv);
    chk("R4 upper byte", b, 8'hA5);
    chk("R4 upper valid", bv, 1);
    rRead(10'd100, 0, b, bv);
    chk("R4 lower byte", b, 8'hC3);
    rWrite(10'd101, 1, 8'h3C);
    rWrite(10'd101, 0, 8'h81);
    lRead(10'd101, 0, 0, d, v);
    chk("R4 narrow writes as word", d, 16'h3C81);
  endtask

  task automatic testBlockedWrite();
    logic [15:0] d; logic [1:0] v;
    lWrite(10'd300, 16'h2492, 0, 0);
    lAddr = 10'd300; lWrData = 16'h4924; lCeN = 1'b1; lWeN = 1'b0;
    lHiEnN = 1'b0; lLoEnN = 1'b0;
    step(); idleAll();
    rAddr = 10'd300; rUpper = 1'b1; rWrData = 8'h77; rCeN = 1'b1; rWeN = 1'b0;
    step(); idleAll();
    lRead(10'd300, 0, 0, d, v);
    chk("R5 write with chip enable high ignored", d, 16'h2492);
    lAddr = 10'd300; lWrData = 16'h1111; lCeN = 1'b0; lWeN = 1'b1; lOeN = 1'b1;
    lHiEnN = 1'b0; lLoEnN = 1'b0;
    step(); idleAll();
    lRead(10'd300, 0, 0, d, v);
    chk("R5 write enable high ignored", d, 16'h2492);
  endtask

  task automatic testNoOutput();
    lAddr = 10'd5; lCeN = 1'b0; lOeN = 1'b1; lWeN = 1'b1; lHiEnN = 1'b0; lLoEnN = 1'b0;
    rAddr = 10'd100; rCeN = 1'b1; rOeN = 1'b0; rWeN = 1'b1;
    step();
    chk("R6 wide side invalid with OE high", lRdVld, 0);
    chk("R6 wide data zero when invalid", lRdData, 0);
    chk("R6 narrow side invalid with CE high", rRdVld, 0);
    idleAll(); step();
  endtask

  task automatic testMailbox();
    logic [15:0] d; logic [1:0] v; logic [7:0] b; logic bv;
    lWrite(10'h3FF, 16'hBEEF, 0, 0);
    chk("R7 rIntN set by wide write to top", rIntN, 0);
    chk("R7 lIntN untouched", lIntN, 1);
    rRead(10'h3FF, 1, b, bv);
    chk("R7 narrow reads mailbox byte", b, 8'hBE);
    chk("R7 rIntN cleared by narrow read", rIntN, 1);
    rWrite(10'h3FE, 0, 8'h5A);
    chk("R8 lIntN set by narrow write", lIntN, 0);
    chk("R8 rIntN untouched", rIntN, 1);
    lRead(10'h3FE, 0, 0, d, v);
    chk("R8 wide reads mailbox lower byte", d[7:0], 8'h5A);
    chk("R8 lIntN cleared by wide read", lIntN, 1);
  endtask

  task automatic testSetWins();
    logic [7:0] b; logic bv;
    lWrite(10'h3FF, 16'h1234, 0, 0);
    chk("R9 flag set before race", rIntN, 0);
    lAddr = 10'h3FF; lWrData = 16'h5678; lCeN = 1'b0; lWeN = 1'b0; lOeN = 1'b1;
    lHiEnN = 1'b0; lLoEnN = 1'b0;
    rAddr = 10'h3FF; rUpper = 1'b0; rCeN = 1'b0; rOeN = 1'b0; rWeN = 1'b1;
    step(); idleAll();
    chk("R9 set wins over same-cycle clear", rIntN, 0);
    step();
    rRead(10'h3FF, 0, b, bv);
    chk("R9 clear alone afterwards", rIntN, 1);
  endtask

  task automatic testBusy();
    idleAll(); step();
    lAddr = 10'd55; lCeN = 1'b0;
    step();
    chk("R10 no busy with one side", {lBusyN, rBusyN}, 2'b11);
    rAddr = 10'd55; rCeN = 1'b0;
    step();
    chk("R10 later right side busy", rBusyN, 0);
    chk("R10 earlier left side free", lBusyN, 1);
    rAddr = 10'd56;
    step();
    chk("R10 busy releases on differing address", rBusyN, 1);
    idleAll(); step();
    rAddr = 10'd9; rCeN = 1'b0;
    step();
    lAddr = 10'd9; lCeN = 1'b0;
    step();
    chk("R10 later left side busy", lBusyN, 0);
    chk("R10 earlier right side free", rBusyN, 1);
    lCeN = 1'b1;
    step();
    chk("R10 busy releases on chip disable", lBusyN, 1);
    idleAll(); step();
    lAddr = 10'd12; rAddr = 10'd12; lCeN = 1'b0; rCeN = 1'b0;
    step();
    chk("R11 tie gives right busy", rBusyN, 0);
    chk("R11 tie leaves left free", lBusyN, 1);
    idleAll(); step();
  endtask

  task automatic testCollision();
    logic [15:0] d; logic [1:0] v; logic [7:0] b; logic bv;
    lAddr = 10'd30; lCeN = 1'b0;
    step();
    rAddr = 10'd30; rUpper = 1'b1; rWrData = 8'h77; rCeN = 1'b0; rWeN = 1'b0;
    step();
    chk("R12 writer sees busy", rBusyN, 0);
    idleAll(); step();
    rRead(10'd30, 1, b, bv);
    chk("R12 busy write still stored", b, 8'h77);
    lAddr = 10'd40; lWrData = 16'h1234; lCeN = 1'b0; lWeN = 1'b0;
    lHiEnN = 1'b0; lLoEnN = 1'b0;
    rAddr = 10'd40; rUpper = 1'b0; rWrData = 8'hEE; rCeN = 1'b0; rWeN = 1'b0;
    step(); idleAll(); step();
    lRead(10'd40, 0, 0, d, v);
    chk("R12 same byte collision wide wins", d, 16'h1234);
    lAddr = 10'd41; lWrData = 16'h0056; lCeN = 1'b0; lWeN = 1'b0;
    lHiEnN = 1'b1; lLoEnN = 1'b0;
    rAddr = 10'd41; rUpper = 1'b1; rWrData = 8'h99; rCeN = 1'b0; rWeN = 1'b0;
    step(); idleAll(); step();
    lRead(10'd41, 0, 0, d, v);
    chk("R12 different bytes both stored", d, 16'h9956);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    testReset();
    rstN = 1'b1;
    step();
    testReset();
    testWord();
    testLanes();
    testNarrow();
    testBlockedWrite();
    testNoOutput();
    testMailbox();
    testSetWins();
    testBusy();
    testCollision();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule